// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines, ranks them by a fixed priority and raises a single interrupt line towards the processor. Software talks to it through a byte-wide port with one address bit, a chip select and separate read and write strobes. Three internal 8-bit registers hold its state: the pending requests, the per-input blocking mask and the set of interrupts being serviced.

After reset, or whenever software chooses, a write with address bit 0 and data bit 4 set starts a locked programming sequence. The sequence sets the trigger style, the vector base, an optional cascade word and an optional mode word. Once the sequence is complete the block accepts run-time commands. These are mask access, a choice of which register a low-address read returns, and the end-of-interrupt command that releases the highest-ranked serviced input. A one-cycle acknowledge pulse latches the winning input and returns an 8-bit vector: the programmed base with its low three bits replaced by the input number.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the interrupt output is low, the mask reads 0x00 at address 1 and a read at address 0 returns the request register, which is 0x00.
- R2: A write at address 0 with data bit 4 set restarts setup at any time. Its bit 3 selects level (1) or edge (0) triggering, its bit 1 set skips the cascade word, and its bit 0 set demands a mode word. It clears the mask and in-service registers and the request register, and it selects the request register for address-0 reads.
- R3: During setup, address-0 writes without bit 4 are ignored. Each address-1 write fills the next expected word: base, then cascade word unless skipped, then mode word if demanded. After the last expected word, address-1 writes reach the mask again.
- R4: The acknowledge vector, visible the cycle after the acknowledge pulse, carries bits 7..3 of the base word and the 3-bit winning input number in bits 2..0.
- R5: In run mode an address-1 write loads the mask and an address-1 read returns it.
- R6: In run mode, writing 0x0A at address 0 makes address-0 reads return the in-service register, and writing 0x0B makes them return the request register.
- R7: The interrupt output is high only when some unmasked request is pending and its highest-ranked bit outranks every in-service bit. Input 0 has the highest rank.
- R8: An acknowledge while the output is high clears the winning request bit in edge mode and, without automatic end-of-interrupt, sets its in-service bit.
- R9: Writing 0x20 at address 0 in run mode clears the highest-ranked set in-service bit only.
- R10: With bit 1 of the mode word set (automatic end-of-interrupt), an acknowledge leaves the in-service register unchanged.
- R11: In level mode each request bit follows its input, and an acknowledge does not clear it.
- R12: An acknowledge while the output is low returns the base with input number 7 and changes no register.
- R13: In edge mode a request is latched on a low-to-high input change. An input held high after being acknowledged does not request again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for the register port |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe, one cycle per write |
| a0 | input | 1 | Register address bit |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, zero when not reading |
| irq | input | 8 | Interrupt request inputs, bit 0 highest rank |
| inta | input | 1 | One-cycle acknowledge pulse |
| intOut | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector captured on acknowledge |

## Verification
The hardest state to reach is a nested one. It needs one input in service while a higher-ranked input arrives and a lower-ranked one waits behind it. From there each end-of-interrupt must release exactly one level and re-expose only what now outranks the remainder. The stimulus table builds that state step by step: it acknowledges a mid-rank input, then unmasks a higher one and acknowledges it too, and it walks back out with single end-of-interrupt writes, checking the output after each step. Directed runs then cover the setup lock, a restart in the middle of setup, level triggering with automatic end-of-interrupt, and an acknowledge with nothing pending.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_BASE  = 2'd1,
    ST_CASC  = 2'd2,
    ST_MODE  = 2'd3
  } setupState_t;

  typedef struct packed {
    logic initStart;
    logic loadBase;
    logic loadMode;
    logic loadMask;
    logic eoi;
    logic ack;
    logic setSel;
    logic selIsr;
  } ctrlStrobe_t;

endpackage

// File: rtl/prio_irq_ctrlpath.sv
module prio_irq_ctrlpath
  import prio_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              wr,
  input  logic              a0,
  input  logic [DATA_W-1:0] wrData,
  input  logic              inta,
  output ctrlStrobe_t       strobe,
  output logic              runMode
);

  localparam logic [2:0] EOI_CODE = 3'b001;

  setupState_t state, nextState;
  logic singleMode;
  logic needMode;
  logic wrEn;
  logic isStart;

  assign wrEn    = cs && wr;
  assign isStart = wrEn && !a0 && wrData[4];
  assign runMode = (state == ST_RUN);

  always_comb begin
    strobe    = '0;
    nextState = state;
    if (isStart) begin
      strobe.initStart = 1'b1;
      nextState        = ST_BASE;
    end else if (wrEn && a0) begin
      unique case (state)
        ST_RUN: strobe.loadMask = 1'b1;
        ST_BASE: begin
          strobe.loadBase = 1'b1;
          if (!singleMode)   nextState = ST_CASC;
          else if (needMode) nextState = ST_MODE;
          else               nextState = ST_RUN;
        end
        ST_CASC: nextState = needMode ? ST_MODE : ST_RUN;
        ST_MODE: begin
          strobe.loadMode = 1'b1;
          nextState       = ST_RUN;
        end
        default: nextState = ST_RUN;
      endcase
    end else if (wrEn && !a0 && (state == ST_RUN)) begin
      if (wrData[4:3] == 2'b01 && wrData[2:1] == 2'b01 && wrData[7:5] == 3'b000) begin
        strobe.setSel = 1'b1;
        strobe.selIsr = !wrData[0];
      end
      if (wrData[4:3] == 2'b00 && wrData[7:5] == EOI_CODE) begin
        strobe.eoi = 1'b1;
      end
    end
    strobe.ack = inta && (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_RUN;
      singleMode <= 1'b0;
      needMode   <= 1'b0;
    end else begin
      state <= nextState;
      if (isStart) begin
        singleMode <= wrData[1];
        needMode   <= wrData[0];
      end
    end
  end

  // R3
  setup_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_RUN && wrEn && !a0 && !wrData[4]) |=> (state == $past(state)));

  // R2
  skip_casc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BASE && wrEn && a0 && singleMode && !needMode) |=> (state == ST_RUN));

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    isStart |=> (state == ST_BASE));

endmodule

// File: rtl/prio_irq_datapath.sv
module prio_irq_datapath
  import prio_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              runMode,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              a0,
  input  logic [DATA_W-1:0] irq,
  output logic [DATA_W-1:0] rdData,
  output logic              intOut,
  output logic [DATA_W-1:0] vector
);

  localparam int IDX_W  = $clog2(DATA_W);
  localparam int BASE_W = DATA_W - IDX_W;

  logic [DATA_W-1:0] reqReg;
  logic [DATA_W-1:0] maskReg;
  logic [DATA_W-1:0] isrReg;
  logic [DATA_W-1:0] prevIrq;
  logic [DATA_W-1:0] pending;
  logic [DATA_W-1:0] ackClr;
  logic [DATA_W-1:0] isrSet;
  logic [DATA_W-1:0] isrClr;
  logic [BASE_W-1:0] baseReg;
  logic              levelMode;
  logic              autoEoi;
  logic              selIsr;
  logic              pendHit;
  logic              isrHit;
  logic [IDX_W-1:0]  pendIdx;
  logic [IDX_W-1:0]  isrIdx;
  logic              grant;

  assign pending = reqReg & ~maskReg;

  always_comb begin
    pendHit = 1'b0;
    pendIdx = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (pending[i]) begin
        pendHit = 1'b1;
        pendIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    isrHit = 1'b0;
    isrIdx = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (isrReg[i]) begin
        isrHit = 1'b1;
        isrIdx = IDX_W'(i);
      end
    end
  end

  assign intOut = runMode && pendHit && (!isrHit || (pendIdx < isrIdx));
  assign grant  = strobe.ack && intOut;

  assign ackClr = (grant && !levelMode) ? (DATA_W'(1) << pendIdx) : '0;
  assign isrSet = (grant && !autoEoi)   ? (DATA_W'(1) << pendIdx) : '0;
  assign isrClr = (strobe.eoi && isrHit) ? (DATA_W'(1) << isrIdx) : '0;

  generate
    for (genvar g = 0; g < DATA_W; g++) begin : g_req
      always_ff @(posedge clk) begin
        if (!rstN) begin
          reqReg[g] <= 1'b0;
        end else if (strobe.initStart) begin
          reqReg[g] <= 1'b0;
        end else if (levelMode) begin
          reqReg[g] <= irq[g];
        end else if (ackClr[g]) begin
          reqReg[g] <= 1'b0;
        end else if (irq[g] && !prevIrq[g]) begin
          reqReg[g] <= 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIrq   <= '0;
      maskReg   <= '0;
      isrReg    <= '0;
      baseReg   <= '0;
      levelMode <= 1'b0;
      autoEoi   <= 1'b0;
      selIsr    <= 1'b0;
      vector    <= '0;
    end else begin
      prevIrq <= irq;
      if (strobe.initStart) begin
        maskReg   <= '0;
        isrReg    <= '0;
        levelMode <= wrData[3];
        autoEoi   <= 1'b0;
        selIsr    <= 1'b0;
      end else begin
        if (strobe.loadMask) maskReg <= wrData;
        if (strobe.loadBase) baseReg <= wrData[DATA_W-1:IDX_W];
        if (strobe.loadMode) autoEoi <= wrData[1];
        if (strobe.setSel)   selIsr  <= strobe.selIsr;
        isrReg <= (isrReg & ~isrClr) | isrSet;
      end
      if (strobe.ack) begin
        vector <= {baseReg, (intOut ? pendIdx : {IDX_W{1'b1}})};
      end
    end
  end

  always_comb begin
    if (!rdEn)      rdData = '0;
    else if (a0)    rdData = maskReg;
    else if (selIsr) rdData = isrReg;
    else            rdData = reqReg;
  end

  // R2
  init_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.initStart |=> (maskReg == '0 && isrReg == '0 && !selIsr));

  // R8
  ack_service_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grant && !autoEoi && !strobe.initStart) |=> (isrReg != '0));

  // R10
  auto_eoi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ack && autoEoi && !strobe.eoi && !strobe.initStart) |=> (isrReg == $past(isrReg)));

  // R9
  eoi_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eoi && !strobe.ack && !strobe.initStart && isrReg != '0)
      |=> ($countones(isrReg) == $countones($past(isrReg)) - 1));

  // R4
  vector_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ack |=> (vector[DATA_W-1:IDX_W] == $past(baseReg)));

  // R7
  quiet_in_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runMode |-> !intOut);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic              a0,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] irq,
  input  logic              inta,
  output logic              intOut,
  output logic [DATA_W-1:0] vector
);

  ctrlStrobe_t strobe;
  logic        runMode;
  logic        rdEn;

  assign rdEn = cs && rd;

  prio_irq_ctrlpath #(.DATA_W(DATA_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cs      (cs),
    .wr      (wr),
    .a0      (a0),
    .wrData  (wrData),
    .inta    (inta),
    .strobe  (strobe),
    .runMode (runMode)
  );

  prio_irq_datapath #(.DATA_W(DATA_W)) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .runMode (runMode),
    .wrData  (wrData),
    .rdEn    (rdEn),
    .a0      (a0),
    .irq     (irq),
    .rdData  (rdData),
    .intOut  (intOut),
    .vector  (vector)
  );

endmodule

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;

  localparam logic [2:0] OP_WR  = 3'd0;
  localparam logic [2:0] OP_RD  = 3'd1;
  localparam logic [2:0] OP_IRQ = 3'd2;
  localparam logic [2:0] OP_ACK = 3'd3;
  localparam logic [2:0] OP_INT = 3'd4;
  localparam int NSTIM = 38;

  // {req, op, a0, data, expected}
  localparam logic [23:0] STIM [0:NSTIM-1] = '{
    {4'd2,  OP_WR,  1'b0, 8'h11, 8'h00},  // R2 start: edge, cascade, mode word
    {4'd3,  OP_WR,  1'b1, 8'h48, 8'h00},  // R3 base
    {4'd3,  OP_WR,  1'b1, 8'h04, 8'h00},  // R3 cascade word
    {4'd3,  OP_WR,  1'b1, 8'h01, 8'h00},  // R3 mode word
    {4'd2,  OP_RD,  1'b1, 8'h00, 8'h00},  // R2 mask cleared
    {4'd5,  OP_WR,  1'b1, 8'h0F, 8'h00},  // R5
    {4'd5,  OP_RD,  1'b1, 8'h00, 8'h0F},  // R5
    {4'd13, OP_IRQ, 1'b0, 8'h21, 8'h00},  // R13
    {4'd7,  OP_INT, 1'b0, 8'h00, 8'h01},  // R7
    {4'd6,  OP_RD,  1'b0, 8'h00, 8'h21},  // R6
    {4'd8,  OP_ACK, 1'b0, 8'h00, 8'h4D},  // R8
    {4'd7,  OP_INT, 1'b0, 8'h00, 8'h00},  // R7
    {4'd6,  OP_WR,  1'b0, 8'h0A, 8'h00},  // R6
    {4'd6,  OP_RD,  1'b0, 8'h00, 8'h20},  // R6
    {4'd5,  OP_WR,  1'b1, 8'h00, 8'h00},  // R5
    {4'd7,  OP_INT, 1'b0, 8'h00, 8'h01},  // R7
    {4'd4,  OP_ACK, 1'b0, 8'h00, 8'h48},  // R4
    {4'd8,  OP_RD,  1'b0, 8'h00, 8'h21},  // R8
    {4'd9,  OP_WR,  1'b0, 8'h20, 8'h00},  // R9
    {4'd9,  OP_RD,  1'b0, 8'h00, 8'h20},  // R9
    {4'd6,  OP_WR,  1'b0, 8'h0B, 8'h00},  // R6
    {4'd13, OP_RD,  1'b0, 8'h00, 8'h00},  // R13 held inputs not relatched
    {4'd13, OP_IRQ, 1'b0, 8'h00, 8'h00},  // R13
    {4'd13, OP_IRQ, 1'b0, 8'h04, 8'h00},  // R13
    {4'd7,  OP_INT, 1'b0, 8'h00, 8'h01},  // R7
    {4'd13, OP_IRQ, 1'b0, 8'h00, 8'h00},  // R13
    {4'd13, OP_RD,  1'b0, 8'h00, 8'h04},  // R13 latch survives input drop
    {4'd13, OP_IRQ, 1'b0, 8'h40, 8'h00},  // R13
    {4'd13, OP_RD,  1'b0, 8'h00, 8'h44},  // R13
    {4'd8,  OP_ACK, 1'b0, 8'h00, 8'h4A},  // R8
    {4'd7,  OP_INT, 1'b0, 8'h00, 8'h00},  // R7 blocked by rank 2
    {4'd9,  OP_WR,  1'b0, 8'h20, 8'h00},  // R9
    {4'd7,  OP_INT, 1'b0, 8'h00, 8'h00},  // R7 blocked by rank 5
    {4'd9,  OP_WR,  1'b0, 8'h20, 8'h00},  // R9
    {4'd7,  OP_INT, 1'b0, 8'h00, 8'h01},  // R7
    {4'd4,  OP_ACK, 1'b0, 8'h00, 8'h4E},  // R4
    {4'd9,  OP_WR,  1'b0, 8'h20, 8'h00},  // R9
    {4'd7,  OP_INT, 1'b0, 8'h00, 8'h00}   // R7
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cs = 1'b0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic       a0 = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] irq = '0;
  logic       inta = 1'b0;
  logic       intOut;
  logic [7:0] vector;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .a0(a0),
    .wrData(wrData), .rdData(rdData), .irq(irq), .inta(inta),
    .intOut(intOut), .vector(vector)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic addr, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; a0 = addr; wrData = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic rdReg(input logic addr, output logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; a0 = addr;
    #1 v = rdData;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic setIrq(input logic [7:0] v);
    @(negedge clk);
    irq = v;
    @(negedge clk);
  endtask

  task automatic ackPulse(output logic [7:0] v);
    @(negedge clk);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    #1 v = vector;
  endtask

  task automatic intSample(output logic [7:0] v);
    @(negedge clk);
    #1 v = {7'd0, intOut};
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    logic [7:0] v;
    string tag;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    intSample(v); check("R1", v, 8'h00);
    rdReg(1'b1, v); check("R1", v, 8'h00);
    rdReg(1'b0, v); check("R1", v, 8'h00);

    for (int k = 0; k < NSTIM; k++) begin
      tag = $sformatf("R%0d", STIM[k][23:20]);
      case (STIM[k][19:17])
        OP_WR:  wrReg(STIM[k][16], STIM[k][15:8]);
        OP_RD:  begin rdReg(STIM[k][16], v); check(tag, v, STIM[k][7:0]); end
        OP_IRQ: setIrq(STIM[k][15:8]);
        OP_ACK: begin ackPulse(v); check(tag, v, STIM[k][7:0]); end
        default: begin intSample(v); check(tag, v, STIM[k][7:0]); end
      endcase
    end
    setIrq(8'h00);

    // R11 / R10: level triggered, single, automatic end-of-interrupt
    wrReg(1'b0, 8'h1B);
    wrReg(1'b1, 8'h80);
    wrReg(1'b1, 8'h03);
    wrReg(1'b1, 8'hF7);
    rdReg(1'b1, v); check("R2", v, 8'hF7);
    setIrq(8'h08);
    rdReg(1'b0, v); check("R11", v, 8'h08);
    intSample(v); check("R7", v, 8'h01);
    ackPulse(v); check("R4", v, 8'h83);
    wrReg(1'b0, 8'h0A);
    rdReg(1'b0, v); check("R10", v, 8'h00);
    wrReg(1'b0, 8'h0B);
    rdReg(1'b0, v); check("R11", v, 8'h08);
    intSample(v); check("R11", v, 8'h01);
    setIrq(8'h00);
    rdReg(1'b0, v); check("R11", v, 8'h00);
    intSample(v); check("R11", v, 8'h00);

    // R3: setup lock ignores address-0 commands
    wrReg(1'b0, 8'h11);
    wrReg(1'b0, 8'h0A);
    wrReg(1'b0, 8'h20);
    wrReg(1'b1, 8'h50);
    wrReg(1'b1, 8'h00);
    wrReg(1'b1, 8'h00);
    wrReg(1'b1, 8'h3C);
    rdReg(1'b1, v); check("R3", v, 8'h3C);
    rdReg(1'b0, v); check("R3", v, 8'h00);
    setIrq(8'h02);
    ackPulse(v); check("R3", v, 8'h51);
    wrReg(1'b0, 8'h0A);
    rdReg(1'b0, v); check("R8", v, 8'h02);

    // R2: restart in the middle of setup
    wrReg(1'b0, 8'h13);
    wrReg(1'b0, 8'h12);
    wrReg(1'b1, 8'h60);
    wrReg(1'b1, 8'h81);
    rdReg(1'b1, v); check("R2", v, 8'h81);
    rdReg(1'b0, v); check("R2", v, 8'h00);
    wrReg(1'b0, 8'h0A);
    rdReg(1'b0, v); check("R2", v, 8'h00);

    // R12: acknowledge with nothing pending
    intSample(v); check("R12", v, 8'h00);
    ackPulse(v); check("R12", v, 8'h67);
    rdReg(1'b0, v); check("R12", v, 8'h00);
    rdReg(1'b1, v); check("R12", v, 8'h81);

    // R1: reset during operation
    setIrq(8'h12);
    intSample(v); check("R7", v, 8'h01);
    ackPulse(v); check("R4", v, 8'h64);
    setIrq(8'h00);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    intSample(v); check("R1", v, 8'h00);
    rdReg(1'b1, v); check("R1", v, 8'h00);
    rdReg(1'b0, v); check("R1", v, 8'h00);

    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

endmodule